// File: doc/BRIEF.md
# Panel polarity inversion pattern generator

This block tells a liquid crystal column driver which drive polarity to apply to each pixel as the panel is scanned. Each pixel clock cycle presents one pixel (or one column group of sub-pixels). A line-start strobe marks the first pixel of a row. A frame-start strobe marks the first pixel of a frame, and it also counts as a line start. From the scan position and a two-bit mode, the block produces a registered polarity bit for the pixel. It also produces a line-level polarity, which is the polarity of column 0 of the current row.

Four inversion schemes are supported: whole-frame, row-alternating, column-alternating and checkerboard. A frame phase flips at every frame start, so every pixel alternates its drive polarity from one frame to the next and carries no net DC bias. The polarity is the frame phase XOR a row-parity term XOR a column-parity term. The mode decides which of the two parity terms take part. A mode change on the input waits for the next frame start, so a frame is never driven with a mix of patterns.

Top module: `pol_pattern_gen`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, pol_o and line_pol_o are 0.
- R2: Mode 2'b00 (frame): every pixel of a frame has a polarity equal to the frame phase.
- R3: Mode 2'b01 (line): the polarity is the frame phase XOR the row parity, where row 0 of a frame has parity 0. Adjacent rows therefore differ, and all pixels of one row are equal.
- R4: Mode 2'b10 (column): the polarity is the frame phase XOR the column parity, where column 0 of a line has parity 0. Adjacent column groups therefore differ.
- R5: Mode 2'b11 (dot): the polarity is the frame phase XOR the row parity XOR the column parity, which gives a checkerboard.
- R6: The frame phase is 0 after reset and inverts at each frame-start strobe, starting with the frame-start pixel itself. The first frame after reset therefore has phase 1.
- R7: The mode is sampled only on a frame-start cycle. Changes of mode_i on other cycles have no effect on pol_o or line_pol_o.
- R8: The column parity restarts at 0 on every line-start or frame-start pixel, whatever the length of the previous line. The row parity restarts at 0 on every frame-start pixel, whatever the number of rows in the previous frame.
- R9: pol_o is registered. It shows, one clock after a pixel's cycle, the polarity of the pixel presented in that cycle, and strobes act on the pixel of their own cycle.
- R10: line_pol_o shows, with the same one-cycle latency, the frame phase XOR (row parity when the mode is line or dot, otherwise 0).
- R11: With parameter COL_GROUP = G, the column parity toggles after every G pixels of a line. Pixel index k of a line (k = 0 at the line start) has column parity (k / G) mod 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start_i | input | 1 | First pixel of a row in this cycle |
| frame_start_i | input | 1 | First pixel of a frame in this cycle (also a line start) |
| mode_i | input | 2 | Inversion mode: 00 frame, 01 line, 10 column, 11 dot |
| pol_o | output | 1 | Registered drive polarity of the previous cycle's pixel |
| line_pol_o | output | 1 | Registered polarity of column 0 of the previous cycle's row |

## Verification
A wrong parity or phase register shows at pol_o on the next pixel that uses it. A stuck column parity shows within COL_GROUP + 1 cycles in column or dot mode. A stuck row parity shows on the first pixel of the second row in line or dot mode. A phase that fails to flip shows on the first pixel of the next frame in every mode. A mode latched at the wrong time shows at the first pixel where the two patterns disagree, which in practice falls within one row. Because the bench compares both outputs against its model on every pixel, each of these faults is caught within the row it occurs in.

// File: rtl/pol_pkg.sv
package pol_pkg;
  typedef enum logic [1:0] {
    POL_FRAME  = 2'b00,
    POL_LINE   = 2'b01,
    POL_COLUMN = 2'b10,
    POL_DOT    = 2'b11
  } pol_mode_e;

  localparam int unsigned POL_MODE_W = 2;
endpackage

// File: rtl/pol_scan_track.sv
module pol_scan_track #(
  parameter int unsigned COL_GROUP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start_i,
  input  logic frame_start_i,
  output logic row_par_o,
  output logic col_par_o
);
  logic row_q, row_d;
  logic col_q, col_d;
  logic restart_col;

  assign restart_col = line_start_i | frame_start_i;

  always_comb begin
    if (frame_start_i)     row_d = 1'b0;
    else if (line_start_i) row_d = ~row_q;
    else                   row_d = row_q;
  end

  generate
    if (COL_GROUP <= 1) begin : g_direct
      always_comb begin
        if (restart_col) col_d = 1'b0;
        else             col_d = ~col_q;
      end
    end else begin : g_grouped
      localparam int unsigned CNT_W = $clog2(COL_GROUP);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COL_GROUP - 1);
      logic [CNT_W-1:0] cnt_q, cnt_d;

      always_comb begin
        if (restart_col) begin
          cnt_d = '0;
          col_d = 1'b0;
        end else if (cnt_q == CNT_LAST) begin
          cnt_d = '0;
          col_d = ~col_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
          col_d = col_q;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= 1'b0;
      col_q <= 1'b0;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  assign row_par_o = row_d;
  assign col_par_o = col_d;

  // R8
  row_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> !row_q);

  // R8
  col_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start_i || frame_start_i) |=> !col_q);
endmodule

// File: rtl/pol_frame_ctrl.sv
module pol_frame_ctrl
  import pol_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start_i,
  input  logic [POL_MODE_W-1:0] mode_i,
  output logic                  phase_o,
  output pol_mode_e             mode_o
);
  logic      phase_q, phase_d;
  pol_mode_e mode_q, mode_d;

  always_comb begin
    phase_d = phase_q;
    mode_d  = mode_q;
    if (frame_start_i) begin
      phase_d = ~phase_q;
      mode_d  = pol_mode_e'(mode_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      mode_q  <= POL_FRAME;
    end else begin
      phase_q <= phase_d;
      mode_q  <= mode_d;
    end
  end

  assign phase_o = phase_d;
  assign mode_o  = mode_d;

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> $stable(mode_q));

  // R6
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (phase_q != $past(phase_q)));

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> $stable(phase_q));
endmodule

// File: rtl/pol_combiner.sv
module pol_combiner
  import pol_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      phase_i,
  input  logic      row_par_i,
  input  logic      col_par_i,
  input  pol_mode_e mode_i,
  output logic      pol_o,
  output logic      line_pol_o
);
  logic use_row, use_col;
  logic line_pol_d, pol_d;

  assign use_row = mode_i[0];
  assign use_col = mode_i[1];

  always_comb begin
    line_pol_d = phase_i ^ (row_par_i & use_row);
    pol_d      = line_pol_d ^ (col_par_i & use_col);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_o      <= 1'b0;
      line_pol_o <= 1'b0;
    end else begin
      pol_o      <= pol_d;
      line_pol_o <= line_pol_d;
    end
  end
endmodule

// File: rtl/pol_pattern_gen.sv
module pol_pattern_gen
  import pol_pkg::*;
#(
  parameter int unsigned COL_GROUP = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start_i,
  input  logic       frame_start_i,
  input  logic [1:0] mode_i,
  output logic       pol_o,
  output logic       line_pol_o
);
  logic      phase_cur;
  logic      row_cur;
  logic      col_cur;
  pol_mode_e mode_cur;

  pol_frame_ctrl u_frame (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start_i),
    .mode_i        (mode_i),
    .phase_o       (phase_cur),
    .mode_o        (mode_cur)
  );

  pol_scan_track #(.COL_GROUP(COL_GROUP)) u_scan (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_start_i  (line_start_i),
    .frame_start_i (frame_start_i),
    .row_par_o     (row_cur),
    .col_par_o     (col_cur)
  );

  pol_combiner u_comb (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_i    (phase_cur),
    .row_par_i  (row_cur),
    .col_par_i  (col_cur),
    .mode_i     (mode_cur),
    .pol_o      (pol_o),
    .line_pol_o (line_pol_o)
  );

  // R2
  frame_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == POL_FRAME && !frame_start_i) |=> $stable(pol_o));

  // R3
  line_row_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == POL_LINE && !frame_start_i && !line_start_i) |=> $stable(pol_o));

  // R4
  column_line_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == POL_COLUMN && !frame_start_i) |=> $stable(line_pol_o));

  // R5
  dot_follow_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == POL_DOT && !frame_start_i && !line_start_i) |=>
      ((pol_o != $past(pol_o)) == ($past(col_cur) != $past(col_cur, 2))));
endmodule

// File: tb/pol_pattern_gen_tb_top.sv
module pol_pattern_gen_tb_top;
  localparam int G2 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ls = 1'b0;
  logic fs = 1'b0;
  logic [1:0] mode = 2'b00;
  logic pol1, lpol1, pol3, lpol3;

  int n_checks = 0;
  int n_fail = 0;

  int m_col, m_row, m_phase, m_mode;
  logic e_pol1, e_lpol, e_pol3;

  always #10 clk = ~clk;

  pol_pattern_gen #(.COL_GROUP(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_start_i(ls), .frame_start_i(fs),
    .mode_i(mode), .pol_o(pol1), .line_pol_o(lpol1)
  );

  pol_pattern_gen #(.COL_GROUP(G2)) dut_g3_i (
    .clk(clk), .rst_n(rst_n), .line_start_i(ls), .frame_start_i(fs),
    .mode_i(mode), .pol_o(pol3), .line_pol_o(lpol3)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (row %0d col %0d)", tag, act, exp, m_row, m_col);
    end
  endtask

  // Drive one pixel at a negedge, update the model at the posedge, compare at the next negedge.
  task automatic pixel(input string tag, input logic l, input logic f, input logic [1:0] md);
    int rowp, colp1, colp3, ur, uc;
    ls = l; fs = f; mode = md;
    @(posedge clk);
    if (f) begin
      m_phase = 1 - m_phase;
      m_mode = md;
      m_row = 0;
      m_col = 0;
    end else if (l) begin
      m_row++;
      m_col = 0;
    end else begin
      m_col++;
    end
    rowp = m_row % 2;
    colp1 = m_col % 2;
    colp3 = (m_col / G2) % 2;
    ur = m_mode % 2;
    uc = m_mode / 2;
    e_lpol = logic'((m_phase ^ (rowp & ur)) & 1);
    e_pol1 = logic'((m_phase ^ (rowp & ur) ^ (colp1 & uc)) & 1);
    e_pol3 = logic'((m_phase ^ (rowp & ur) ^ (colp3 & uc)) & 1);
    @(negedge clk);
    chk(tag, pol1, e_pol1);
    chk("R10", lpol1, e_lpol);
    chk("R11", pol3, e_pol3);
    chk("R10", lpol3, e_lpol);
  endtask

  task automatic frame(input string tag, input logic [1:0] md, input logic [1:0] mid,
                       input int rows, input int cols);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++)
        pixel((r == 0 && c == 0) ? "R6" : tag, c == 0, r == 0 && c == 0,
              (r == 0 && c == 0) ? md : mid);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    m_col = 0; m_row = 0; m_phase = 0; m_mode = 0;
    repeat (3) @(negedge clk);
    chk("R1", pol1, 1'b0);
    chk("R1", lpol1, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", pol1, 1'b0);
    chk("R1", lpol1, 1'b0);

    frame("R2", 2'b00, 2'b00, 3, 7);
    frame("R3", 2'b01, 2'b01, 4, 6);
    frame("R4", 2'b10, 2'b10, 3, 8);
    frame("R5", 2'b11, 2'b11, 4, 7);
    frame("R5", 2'b11, 2'b11, 3, 5);
    // R7: mode input moves mid-frame, latched mode must hold
    frame("R7", 2'b00, 2'b11, 3, 6);
    frame("R7", 2'b10, 2'b01, 3, 7);
    frame("R7", 2'b01, 2'b10, 4, 5);

    // R8: irregular line lengths and a frame cut short mid-line
    pixel("R8", 1'b1, 1'b1, 2'b11);
    for (int c = 1; c < 5; c++) pixel("R8", 1'b0, 1'b0, 2'b00);
    pixel("R8", 1'b1, 1'b0, 2'b00);
    pixel("R8", 1'b0, 1'b0, 2'b00);
    pixel("R8", 1'b1, 1'b0, 2'b01);
    for (int c = 1; c < 9; c++) pixel("R8", 1'b0, 1'b0, 2'b00);
    pixel("R8", 1'b1, 1'b1, 2'b11);
    pixel("R8", 1'b0, 1'b0, 2'b11);
    pixel("R8", 1'b1, 1'b0, 2'b11);
    for (int c = 1; c < 4; c++) pixel("R8", 1'b0, 1'b0, 2'b11);
    // R9: back-to-back frame strobes
    pixel("R9", 1'b1, 1'b1, 2'b10);
    pixel("R9", 1'b1, 1'b1, 2'b01);
    pixel("R9", 1'b0, 1'b0, 2'b01);
    frame("R4", 2'b10, 2'b10, 2, 10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule